// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block is a full-duplex synchronous serial port that moves 8-bit frames over a data-out line, a data-in line and a serial clock that it generates itself. Each direction has two stages. A transmit holding register feeds a transmit shifter, and a receive shifter feeds a receive holding register. Software can therefore queue the next byte, or collect the previous one, while a frame is on the wire.

A small register bus gives access to a control register and to a status register. The control register holds separate transmit and receive enables. The status register holds three flags: transmit-empty, receive-full and overrun. Software clears a flag by reading it as 1 and then writing 0 to it. A DMA side path can also write the transmit holding register or read the receive holding register, and each such access clears the matching flag at once. Two request outputs follow the empty and full flags and are intended to trigger that DMA path.

An overrun freezes the port in both directions until software clears it. Full-duplex operation is reached only by enabling both directions from a fully disabled state.

Top module: `sts_xcvr`

## Requirements
- R1: After reset the serial clock and the data-out line are high, both request outputs are low, the control register reads 0, and the status register reads 0x01. The status bits are: bit 0 transmit-empty, bit 1 receive-full, bit 2 overrun.
- R2: A frame is 8 bits, least significant bit first. The data-out line changes only together with a falling edge of the serial clock, or when the port goes idle. Each bit lasts 2*HALF_CYC clock cycles, with the clock low in the first half and high in the second half.
- R3: The data-in line is sampled at each rising edge of the serial clock. When a frame completes and receive-full is 0, the assembled byte goes to the receive holding register (bus address 3) and receive-full becomes 1.
- R4: A transmit frame starts when transmit is active and transmit-empty is 0. The start moves the transmit holding register (bus address 1) into the shifter and sets transmit-empty to 1. If transmit-empty is 0 again when the last bit ends, the next frame follows with no gap. Otherwise the clock and the data-out line stay high.
- R5: tx_req equals transmit-empty AND transmit active. rx_req equals receive-full AND receive active.
- R6: Writing 0 to a status flag clears it only if that flag was read as 1 since it last became 1. Writing 1 has no effect. Writing 0 to a flag that has not been read as 1 has no effect.
- R7: A DMA write loads the transmit holding register and clears transmit-empty. A DMA read returns the receive holding register and clears receive-full.
- R8: If a frame completes while receive-full is 1, overrun is set, the receive holding register keeps its earlier byte, and the new byte is dropped. While overrun is 1, no frame starts in either direction. Frames resume once overrun is cleared.
- R9: The control register is at bus address 0, with bit 0 for the transmit enable and bit 1 for the receive enable. Enables written while both are 0 select the session's directions. Setting a second enable while the first is already set does not activate that direction. Clearing both enables ends the session, so no further frame starts.
- R10: With only reception active, frames run back to back for as long as receive-full is cleared in time, and the data-out line stays high.
- R11: If receive-full is cleared in the same cycle as a frame completes, the clear takes effect first: the new byte is stored, receive-full stays 1, and overrun stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control, 1 transmit holding, 2 status, 3 receive holding |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms the status flags for clearing) |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data, selected by bus_addr |
| dma_tx_we | input | 1 | DMA write to the transmit holding register |
| dma_tx_data | input | DATA_W | DMA transmit byte |
| dma_rx_re | input | 1 | DMA read of the receive holding register |
| dma_rx_data | output | DATA_W | Receive holding register contents for the DMA path |
| tx_req | output | 1 | Transmit DMA/interrupt request |
| rx_req | output | 1 | Receive DMA/interrupt request |
| sck | output | 1 | Serial clock, idles high |
| txd | output | 1 | Serial data out, idles high |
| rxd | input | 1 | Serial data in |

## Verification
Two events can fall in the same cycle: the completion of an incoming frame, and a clear of receive-full by the DMA path. The bench counts the serial clock's falling edges to find the start of bit 7 of a frame. It then times a DMA read so that the strobe is high in exactly the cycle that produces the completing rising edge. The result is judged at the ports. The DMA data seen during the strobe must be the earlier byte. Afterwards the receive holding register must hold the new byte, and the status must show receive-full with no overrun. Overrun itself is provoked separately, by leaving two frames unread and then confirming that the serial clock stops.

// File: rtl/sts_pkg.sv
package sts_pkg;

  localparam logic [1:0] REG_CTRL  = 2'd0;
  localparam logic [1:0] REG_TXBUF = 2'd1;
  localparam logic [1:0] REG_STAT  = 2'd2;
  localparam logic [1:0] REG_RXBUF = 2'd3;

  localparam int ST_TE = 0;
  localparam int ST_RF = 1;
  localparam int ST_OV = 2;

  typedef struct packed {
    logic ov;
    logic rf;
    logic te;
  } flags_t;

  // R9: directions are chosen only when leaving the fully disabled state
  function automatic logic [1:0] next_mode(input logic [1:0] old_ctrl,
                                           input logic [1:0] old_mode,
                                           input logic [1:0] new_ctrl);
    if (old_ctrl == 2'b00) return new_ctrl;
    return old_mode & new_ctrl;
  endfunction

  // R3: one more serial bit enters at the top, LSB-first framing
  function automatic logic [7:0] shift_in8(input logic [7:0] cur, input logic bit_in);
    return {bit_in, cur[7:1]};
  endfunction

endpackage

// File: rtl/sts_bit_timer.sv
module sts_bit_timer #(
  parameter int HALF_CYC = 2,
  parameter int BITS     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic sck,
  output logic busy,
  output logic rise_tick,
  output logic bit_end,
  output logic last_bit,
  output logic frame_start
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int BW = (BITS > 1) ? $clog2(BITS) : 1;

  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;
  logic          high_q;
  logic          half_hit;

  assign half_hit    = (cnt_q == CW'(HALF_CYC - 1));
  assign rise_tick   = busy & ~high_q & half_hit;
  assign bit_end     = busy & high_q & half_hit;
  assign last_bit    = (bit_q == BW'(BITS - 1));
  assign frame_start = go & (~busy | (bit_end & last_bit));

  // R2: low half then high half per bit, clock idles high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sck    <= 1'b1;
      cnt_q  <= '0;
      bit_q  <= '0;
      high_q <= 1'b0;
    end else if (frame_start) begin
      busy   <= 1'b1;
      sck    <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      high_q <= 1'b0;
    end else if (busy) begin
      if (half_hit) begin
        cnt_q <= '0;
        if (!high_q) begin
          high_q <= 1'b1;
          sck    <= 1'b1;
        end else if (last_bit) begin
          busy <= 1'b0;
        end else begin
          bit_q  <= bit_q + 1'b1;
          high_q <= 1'b0;
          sck    <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sts_tx_shift.sv
module sts_tx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tx_on,
  input  logic [DATA_W-1:0] load_data,
  input  logic              bit_end,
  input  logic              last_bit,
  output logic              txd
);
  logic [DATA_W-1:0] sreg_q;
  logic              on_q;

  // R2: data-out moves only with the falling clock at start/shift, or to idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '1;
      on_q   <= 1'b0;
      txd    <= 1'b1;
    end else if (start) begin
      on_q <= tx_on;
      if (tx_on) begin
        sreg_q <= load_data;
        txd    <= load_data[0];
      end else begin
        txd <= 1'b1;
      end
    end else if (bit_end) begin
      if (last_bit) begin
        txd  <= 1'b1;
        on_q <= 1'b0;
      end else begin
        sreg_q <= sreg_q >> 1;
        txd    <= on_q ? sreg_q[1] : 1'b1;
      end
    end
  end

endmodule

// File: rtl/sts_rx_shift.sv
module sts_rx_shift
  import sts_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rx_on,
  input  logic              sample,
  input  logic              last_bit,
  input  logic              rxd,
  output logic              done,
  output logic [DATA_W-1:0] byte_out
);
  logic [DATA_W-1:0] sreg_q;
  logic              on_q;

  assign byte_out = shift_in8(sreg_q, rxd);
  assign done     = sample & last_bit & on_q;

  // R3: sampled on the rising serial clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      on_q   <= 1'b0;
    end else begin
      if (start) on_q <= rx_on;
      if (sample) sreg_q <= byte_out;
    end
  end

endmodule

// File: rtl/sts_xcvr.sv
module sts_xcvr
  import sts_pkg::*;
#(
  parameter int HALF_CYC = 2,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dma_tx_we,
  input  logic [DATA_W-1:0] dma_tx_data,
  input  logic              dma_rx_re,
  output logic [DATA_W-1:0] dma_rx_data,
  output logic              tx_req,
  output logic              rx_req,
  output logic              sck,
  output logic              txd,
  input  logic              rxd
);
  localparam int PADC = DATA_W - 2;
  localparam int PADS = DATA_W - 3;

  logic [1:0]        ctrl_q, mode_q;
  logic [DATA_W-1:0] tdr_q, rx_buf;
  flags_t            fl_q, fl_d, clr_v;
  logic [2:0]        arm_q;
  logic              act_tx, act_rx, go;
  logic              eng_busy, rise_tick, bit_end, last_bit, frame_start;
  logic              tx_load, rx_done, rf_keep, rf_clr;
  logic              te_flag, rf_flag, ov_flag;
  logic              wr_ctrl, wr_tdr, stat_wr, stat_rd;
  logic [DATA_W-1:0] rx_byte;

  assign wr_ctrl = bus_wr & (bus_addr == REG_CTRL);
  assign wr_tdr  = bus_wr & (bus_addr == REG_TXBUF);
  assign stat_wr = bus_wr & (bus_addr == REG_STAT);
  assign stat_rd = bus_rd & (bus_addr == REG_STAT);

  // R9: a direction is live only if it was chosen at session entry
  assign act_tx = ctrl_q[0] & mode_q[0];
  assign act_rx = ctrl_q[1] & mode_q[1];
  // R8, R4, R10: start rules
  assign go      = ~fl_q.ov & (act_tx ? ~fl_q.te : act_rx);
  assign tx_load = frame_start & act_tx;

  assign te_flag = fl_q.te;
  assign rf_flag = fl_q.rf;
  assign ov_flag = fl_q.ov;

  // R5
  assign tx_req = fl_q.te & act_tx;
  assign rx_req = fl_q.rf & act_rx;

  sts_bit_timer #(.HALF_CYC(HALF_CYC), .BITS(DATA_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .go(go), .sck(sck), .busy(eng_busy),
    .rise_tick(rise_tick), .bit_end(bit_end), .last_bit(last_bit),
    .frame_start(frame_start)
  );

  sts_tx_shift #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(frame_start), .tx_on(act_tx),
    .load_data(tdr_q), .bit_end(bit_end), .last_bit(last_bit), .txd(txd)
  );

  sts_rx_shift #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .start(frame_start), .rx_on(act_rx),
    .sample(rise_tick), .last_bit(last_bit), .rxd(rxd),
    .done(rx_done), .byte_out(rx_byte)
  );

  // R6, R7: clear sources per flag
  always_comb begin
    clr_v.te = (stat_wr & arm_q[ST_TE] & ~bus_wdata[ST_TE]) | dma_tx_we;
    clr_v.rf = (stat_wr & arm_q[ST_RF] & ~bus_wdata[ST_RF]) | dma_rx_re;
    clr_v.ov =  stat_wr & arm_q[ST_OV] & ~bus_wdata[ST_OV];
  end
  assign rf_clr  = clr_v.rf;
  // R11: a clear in the completion cycle is applied first
  assign rf_keep = fl_q.rf & ~clr_v.rf;

  always_comb begin
    fl_d.te = tx_load ? 1'b1 : (fl_q.te & ~clr_v.te);
    fl_d.rf = rx_done ? 1'b1 : rf_keep;
    fl_d.ov = (rx_done & rf_keep) | (fl_q.ov & ~clr_v.ov);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_q   <= '{ov: 1'b0, rf: 1'b0, te: 1'b1};
      arm_q  <= '0;
      ctrl_q <= '0;
      mode_q <= '0;
      tdr_q  <= '0;
      rx_buf <= '0;
    end else begin
      fl_q  <= fl_d;
      arm_q <= (arm_q | (stat_rd ? fl_q : 3'b000)) & ~clr_v & fl_d;
      if (wr_ctrl) begin
        ctrl_q <= bus_wdata[1:0];
        mode_q <= next_mode(ctrl_q, mode_q, bus_wdata[1:0]);
      end
      if (dma_tx_we)   tdr_q <= dma_tx_data;
      else if (wr_tdr) tdr_q <= bus_wdata;
      // R3, R8: only an accepted frame updates the buffer
      if (rx_done && !rf_keep) rx_buf <= rx_byte;
    end
  end

  assign dma_rx_data = rx_buf;

  always_comb begin
    unique case (bus_addr)
      REG_CTRL:  bus_rdata = {{PADC{1'b0}}, ctrl_q};
      REG_TXBUF: bus_rdata = tdr_q;
      REG_STAT:  bus_rdata = {{PADS{1'b0}}, fl_q};
      default:   bus_rdata = rx_buf;
    endcase
  end

endmodule

// File: rtl/sts_xcvr_checker.sv
module sts_xcvr_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sck,
  input logic              txd,
  input logic              tx_req,
  input logic              rx_req,
  input logic              te_flag,
  input logic              rf_flag,
  input logic              ov_flag,
  input logic [DATA_W-1:0] rx_buf,
  input logic              frame_start,
  input logic              tx_load,
  input logic              rx_done,
  input logic              rf_clr,
  input logic              eng_busy
);
  AST_TXD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> ($fell(sck) || !eng_busy)); // R2
  AST_FULL_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rf_flag) |-> $past(rx_done)); // R3
  AST_LOAD_SETS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> te_flag); // R4
  AST_TXREQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> te_flag); // R5
  AST_RXREQ_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req |-> rf_flag); // R5
  AST_OVR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    ov_flag |-> !frame_start); // R8
  AST_OVR_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ov_flag) |-> $stable(rx_buf)); // R8
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rf_clr) |=> (rf_flag && !ov_flag)); // R11
endmodule

bind sts_xcvr sts_xcvr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .txd(txd), .tx_req(tx_req),
  .rx_req(rx_req), .te_flag(te_flag), .rf_flag(rf_flag), .ov_flag(ov_flag),
  .rx_buf(rx_buf), .frame_start(frame_start), .tx_load(tx_load),
  .rx_done(rx_done), .rf_clr(rf_clr), .eng_busy(eng_busy)
);

// File: tb/sts_xcvr_bench.sv
`timescale 1ns/1ps
module sts_xcvr_bench;
  localparam int HALF = 2;
  localparam int BIT_CYC = 2 * HALF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'd0, rdata;
  logic dma_tx_we = 1'b0, dma_rx_re = 1'b0;
  logic [7:0] dma_tx_data = 8'd0, dma_rx_data;
  logic tx_req, rx_req, sck, txd;
  logic rxd = 1'b1;

  always #2 clk = ~clk;

  sts_xcvr #(.HALF_CYC(HALF), .DATA_W(8)) u_sts_xcvr (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .dma_tx_we(dma_tx_we),
    .dma_tx_data(dma_tx_data), .dma_rx_re(dma_rx_re), .dma_rx_data(dma_rx_data),
    .tx_req(tx_req), .rx_req(rx_req), .sck(sck), .txd(txd), .rxd(rxd)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // serial peer model: byte sent on the data-in line during frame k
  function automatic logic [7:0] rx_pat(input int k);
    return 8'(((k * 37) + 90) ^ (k << 3));
  endfunction

  function automatic logic [7:0] stat_word(input bit te, input bit rf, input bit ov);
    return {5'b0, ov, rf, te};
  endfunction

  int cyc = 0, fall_cnt = 0, rise_cnt = 0, last_rise = 0, bad_gap = 0, txd_low = 0;
  logic [7:0] tx_cap = 8'd0, rx_cur;
  logic [7:0] tx_log [64];
  int first_gap [64];
  bit rxonly_watch = 0;

  always @(posedge clk) cyc++;

  always @(negedge sck) if (rst_n) begin
    rx_cur = rx_pat(fall_cnt / 8);
    rxd <= rx_cur[fall_cnt % 8];
    fall_cnt++;
  end

  always @(posedge sck) if (rst_n) begin
    if (rise_cnt % 8 == 0) first_gap[(rise_cnt / 8) % 64] = cyc - last_rise;
    else if (cyc - last_rise != BIT_CYC) bad_gap++;
    last_rise = cyc;
    tx_cap = {txd, tx_cap[7:1]};
    if (rxonly_watch && txd !== 1'b1) txd_low++;
    rise_cnt++;
    if (rise_cnt % 8 == 0) tx_log[(rise_cnt / 8 - 1) % 64] = tx_cap;
  end

  // DMA responders
  bit dma_tx_on = 0, dma_rx_on = 0;
  int dma_tx_i = 0, dma_tx_cnt = 0, rx_got_n = 0;
  logic [7:0] dma_q [8];

  initial forever begin
    @(negedge clk);
    if (dma_tx_on && tx_req && dma_tx_i < dma_tx_cnt) begin
      dma_tx_data = dma_q[dma_tx_i];
      dma_tx_we = 1'b1;
      dma_tx_i++;
      @(negedge clk);
      dma_tx_we = 1'b0;
    end
  end

  initial forever begin
    @(negedge clk);
    if (dma_rx_on && rx_req) begin
      chk("R9 duplex rx byte", dma_rx_data, rx_pat(rise_cnt / 8 - 1));
      dma_rx_re = 1'b1;
      rx_got_n++;
      @(negedge clk);
      dma_rx_re = 1'b0;
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1 addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(posedge clk); #1 addr = a; rd = 1'b1;
    #1 d = rdata;
    @(posedge clk); #1 rd = 1'b0;
  endtask

  task automatic wait_frames(input int target);
    for (int t = 0; t < 8000 && rise_cnt < target * 8; t++) @(posedge clk);
  endtask

  task automatic wait_rxreq();
    for (int t = 0; t < 8000 && !rx_req; t++) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] r, b;
    int base, k1, k2, m, rc;
    void'($urandom(32'd2024));
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sck", sck, 1); chk("R1 txd", txd, 1);
    chk("R1 tx_req", tx_req, 0); chk("R1 rx_req", rx_req, 0);
    bus_read(2'd0, r); chk("R1 ctrl", r, 0);
    // R6 unread clear ignored, reset status
    bus_write(2'd2, 8'h00);
    bus_read(2'd2, r); chk("R1 R6 status", r, stat_word(1, 0, 0));
    bus_write(2'd2, 8'h01);
    bus_read(2'd2, r); chk("R6 write one", r, stat_word(1, 0, 0));
    bus_write(2'd2, 8'h00);
    bus_read(2'd2, r); chk("R6 clear after read", r, stat_word(0, 0, 0));

    // R2 single transmit frame
    b = 8'($urandom);
    bus_write(2'd1, b);
    base = rise_cnt / 8;
    bus_write(2'd0, 8'h01);
    wait_frames(base + 1);
    @(negedge clk);
    chk("R2 tx byte", tx_log[base], b);
    chk("R5 tx_req", tx_req, 1);
    repeat (10) @(negedge clk);
    chk("R4 idle sck", sck, 1); chk("R4 idle txd", txd, 1);

    // R7 R4 back-to-back via DMA
    for (int i = 0; i < 6; i++) dma_q[i] = 8'($urandom);
    dma_tx_i = 0; dma_tx_cnt = 6;
    base = rise_cnt / 8;
    dma_tx_on = 1;
    wait_frames(base + 6);
    repeat (20) @(negedge clk);
    dma_tx_on = 0;
    for (int i = 0; i < 6; i++) chk("R7 dma tx byte", tx_log[base + i], dma_q[i]);
    for (int i = 1; i < 6; i++) chk("R4 no gap", first_gap[base + i], BIT_CYC);
    rc = rise_cnt;
    repeat (20) @(negedge clk);
    chk("R4 stops when empty", rise_cnt, rc);
    chk("R2 bit period", bad_gap, 0);

    // R10 R3 receive-only session
    bus_write(2'd0, 8'h00);
    bus_write(2'd0, 8'h02);
    rxonly_watch = 1;
    @(negedge clk);
    chk("R5 tx_req inactive", tx_req, 0);
    wait_rxreq();
    k1 = rise_cnt / 8 - 1;
    chk("R3 rx byte", dma_rx_data, rx_pat(k1));
    dma_rx_re = 1'b1; @(negedge clk); dma_rx_re = 1'b0;
    @(negedge clk);
    chk("R7 dma read clears", rx_req, 0);

    // R8 overrun
    wait_frames(k1 + 3);
    repeat (30) @(negedge clk);
    rc = rise_cnt;
    repeat (40) @(negedge clk);
    chk("R8 halted", rise_cnt, rc);
    bus_read(2'd2, r); chk("R8 status", r, stat_word(1, 1, 1));
    bus_read(2'd3, r); chk("R8 old byte kept", r, rx_pat(k1 + 1));
    bus_write(2'd2, 8'h01);
    wait_rxreq();
    k2 = rise_cnt / 8 - 1;
    chk("R8 resumed", int'(k2 > k1 + 2), 1);
    chk("R8 resumed byte", dma_rx_data, rx_pat(k2));
    dma_rx_re = 1'b1; @(negedge clk); dma_rx_re = 1'b0;

    // R11 clear in the completion cycle
    @(negedge clk);
    wait_rxreq();
    m = rise_cnt / 8 - 1;
    wait (fall_cnt == 8 * (m + 1) + 8);
    repeat (HALF - 1) @(posedge clk);
    #1 chk("R11 old byte at strobe", dma_rx_data, rx_pat(m));
    dma_rx_re = 1'b1;
    @(posedge clk); #1 dma_rx_re = 1'b0;
    chk("R11 full kept", rx_req, 1);
    bus_read(2'd3, r); chk("R11 new byte", r, rx_pat(m + 1));
    bus_read(2'd2, r); chk("R11 no overrun", r, stat_word(1, 1, 0));
    chk("R10 txd high", txd_low, 0);
    rxonly_watch = 0;
    bus_write(2'd0, 8'h00);
    repeat (60) @(negedge clk);
    bus_read(2'd2, r);
    bus_write(2'd2, 8'h01);

    // R9 late second enable does not add reception
    bus_write(2'd0, 8'h01);
    bus_write(2'd0, 8'h03);
    b = 8'($urandom);
    bus_write(2'd1, b);
    bus_read(2'd2, r);
    base = rise_cnt / 8;
    bus_write(2'd2, 8'h00);
    wait_frames(base + 1);
    repeat (10) @(negedge clk);
    chk("R9 tx still works", tx_log[base], b);
    chk("R9 rx_req idle", rx_req, 0);
    bus_read(2'd2, r); chk("R9 no reception", r, stat_word(1, 0, 0));

    // R9 full duplex after restart
    bus_write(2'd0, 8'h00);
    bus_write(2'd0, 8'h03);
    for (int i = 0; i < 3; i++) dma_q[i] = 8'($urandom);
    dma_tx_i = 0; dma_tx_cnt = 3; rx_got_n = 0;
    base = rise_cnt / 8;
    dma_rx_on = 1; dma_tx_on = 1;
    wait_frames(base + 3);
    repeat (20) @(negedge clk);
    dma_tx_on = 0; dma_rx_on = 0;
    for (int i = 0; i < 3; i++) chk("R9 duplex tx byte", tx_log[base + i], dma_q[i]);
    chk("R9 duplex rx count", rx_got_n, 3);
    bus_write(2'd0, 8'h00);
    rc = rise_cnt;
    repeat (50) @(negedge clk);
    chk("R9 session ended", rise_cnt, rc);
    chk("R5 tx_req off", tx_req, 0);

    finished = 1;
    summary();
    $finish;
  end

endmodule